// File: doc/BRIEF.md
# Code-Segment Transfer Protection Checker

This block judges a far control transfer aimed at a nonconforming code segment. The descriptor fetch logic supplies the target selector and the fields it read from the descriptor: the privilege level and the present flag. The sequencer supplies the current privilege level, a flag that marks a transfer routed through a call gate, and the descriptor table limit. One strobe starts the evaluation.

Every protection test is evaluated at the same time. A fixed ranking then selects the single fault to report, with its vector class and a 16-bit error code. One cycle after the strobe the block gives either a fault pulse or an ok pulse. It does not fetch descriptors, switch stacks, load segment registers or apply the rules for conforming segments.

Top module: `segProtChk`

## Requirements
- R1: Results are registered. `faultValid` or `okPulse` is high for exactly the one cycle after a clock edge that sampled `inValid` high, and both are low otherwise. Reset clears every output to zero.
- R2: A privilege fault exists when the selector's requested level (bits 1:0) is greater than `curCpl`, or when `descDpl` differs from `curCpl`. It is reported as general protection with the selector as the error code.
- R3: When `descPresent` is low and no higher-ranked fault exists, the block reports segment-not-present with the selector as the error code.
- R4: When a privilege fault and a not-present condition occur together, the privilege fault (general protection) is reported.
- R5: On the gate path (`viaGate` high), a null selector raises general protection with error code 0. A null selector has bits 15:2 all zero, whatever its requested-level bits hold.
- R6: On the gate path, a non-null selector with `(selector | 7) > tableLimit` raises general protection with the selector as the error code. The table-select bit (bit 2) does not change this test. A selector whose last byte lands exactly on the limit is within bounds.
- R7: The ranking from highest to lowest is null selector, out of limits, privilege, not-present. A limit below 8 never turns a null selector into a limit fault.
- R8: With `viaGate` low, the null and limit tests are not applied, and `tableLimit` has no effect.
- R9: When no test fails, `okPulse` is raised with `faultType` 0 and `errCode` 0. `faultValid` and `okPulse` are never high together.
- R10: `faultType` encoding: 0 = none, 1 = general protection, 2 = segment-not-present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Strobe: inputs hold a transfer to check |
| selector | input | 16 | Target code-segment selector |
| descDpl | input | 2 | Privilege level read from the target descriptor |
| descPresent | input | 1 | Present flag of the target descriptor |
| curCpl | input | 2 | Current privilege level |
| viaGate | input | 1 | Transfer goes through a call gate |
| tableLimit | input | 16 | Byte limit of the descriptor table |
| faultValid | output | 1 | One-cycle fault pulse |
| faultType | output | 2 | Fault class (0 none, 1 GP, 2 NP) |
| errCode | output | 16 | Error code pushed with the fault |
| okPulse | output | 1 | One-cycle pulse: all tests passed |

## Verification
The bench targets the cases where more than one test fails at once. These are a privileged, non-present segment, and a gate with a null selector paired with a tiny limit and bad privilege fields. A design with the ranking wrong would report NP instead of GP there, or push the selector instead of zero. The bench also probes the limit edge, where `selector | 7` equals the limit and where it exceeds the limit by one byte. A less-or-equal comparison or a check on the index alone would flip those results. Further cases cover a null selector with nonzero requested-level bits, a table-select bit that must still be limit-checked, and non-gate transfers that must ignore the limit and the null test.

// File: rtl/segChkPkg.sv
package segChkPkg;
  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_GP   = 2'd1,
    FT_NP   = 2'd2
  } faultKindT;

  // raw outcome of every parallel test
  typedef struct packed {
    logic nullHit;
    logic limitHit;
    logic privHit;
    logic absentHit;
  } checkFlagsT;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;
    logic      raise;
    faultKindT kind;
    logic      errUseSel;
  } ctrlStrobesT;
endpackage

// File: rtl/segChkControl.sv
module segChkControl
  import segChkPkg::*;
(
  input  logic        inValid,
  input  checkFlagsT  flags,
  output ctrlStrobesT strb
);
  always_comb begin
    strb.capture   = inValid;
    strb.raise     = 1'b1;
    strb.kind      = FT_GP;
    strb.errUseSel = 1'b1;
    if (flags.nullHit) begin
      strb.errUseSel = 1'b0;
    end else if (flags.limitHit) begin
      strb.kind = FT_GP;
    end else if (flags.privHit) begin
      strb.kind = FT_GP;
    end else if (flags.absentHit) begin
      strb.kind = FT_NP;
    end else begin
      strb.raise     = 1'b0;
      strb.kind      = FT_NONE;
      strb.errUseSel = 1'b0;
    end
  end
endmodule

// File: rtl/segChkDatapath.sv
module segChkDatapath
  import segChkPkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 16,
  parameter int PL_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SEL_W-1:0]   selector,
  input  logic [PL_W-1:0]    descDpl,
  input  logic               descPresent,
  input  logic [PL_W-1:0]    curCpl,
  input  logic               viaGate,
  input  logic [LIMIT_W-1:0] tableLimit,
  input  ctrlStrobesT        strb,
  output checkFlagsT         flags,
  output logic               faultValid,
  output logic [1:0]         faultType,
  output logic [SEL_W-1:0]   errCode,
  output logic               okPulse
);
  localparam int IDX_LSB = 3;
  localparam int TI_BIT  = 2;
  localparam int CMP_W   = (SEL_W > LIMIT_W) ? SEL_W : LIMIT_W;

  logic [PL_W-1:0]  reqPl;
  logic             nullSel;
  logic [CMP_W-1:0] extentEnd;
  logic [CMP_W-1:0] limitExt;

  always_comb begin
    reqPl     = selector[PL_W-1:0];
    nullSel   = (selector[SEL_W-1:TI_BIT] == '0);
    extentEnd = CMP_W'({selector[SEL_W-1:IDX_LSB], {IDX_LSB{1'b1}}});
    limitExt  = CMP_W'(tableLimit);
    flags.nullHit   = viaGate && nullSel;
    flags.limitHit  = viaGate && (extentEnd > limitExt);
    flags.privHit   = (reqPl > curCpl) || (descDpl != curCpl);
    flags.absentHit = !descPresent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultValid <= 1'b0;
      okPulse    <= 1'b0;
      faultType  <= FT_NONE;
      errCode    <= '0;
    end else begin
      faultValid <= strb.capture && strb.raise;
      okPulse    <= strb.capture && !strb.raise;
      faultType  <= strb.capture ? strb.kind : FT_NONE;
      errCode    <= (strb.capture && strb.raise && strb.errUseSel) ? selector : '0;
    end
  end

  // R9
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(faultValid && okPulse));

  // R1
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid || okPulse) |-> $past(inValid));

  // R1
  strobe_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (faultValid || okPulse));

  // R5
  null_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && viaGate && selector[SEL_W-1:TI_BIT] == '0) |=>
      (faultValid && faultType == FT_GP && errCode == '0));

  // R3
  absent_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultType == FT_NP) |->
      (!$past(descPresent) && errCode == $past(selector)));

  // R4
  priv_over_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !viaGate && descDpl != curCpl) |=>
      (faultValid && faultType == FT_GP));
endmodule

// File: rtl/segProtChk.sv
module segProtChk
  import segChkPkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 16,
  parameter int PL_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SEL_W-1:0]   selector,
  input  logic [PL_W-1:0]    descDpl,
  input  logic               descPresent,
  input  logic [PL_W-1:0]    curCpl,
  input  logic               viaGate,
  input  logic [LIMIT_W-1:0] tableLimit,
  output logic               faultValid,
  output logic [1:0]         faultType,
  output logic [SEL_W-1:0]   errCode,
  output logic               okPulse
);
  checkFlagsT  flags;
  ctrlStrobesT strb;

  segChkControl uCtrl (
    .inValid (inValid),
    .flags   (flags),
    .strb    (strb)
  );

  segChkDatapath #(.SEL_W(SEL_W), .LIMIT_W(LIMIT_W), .PL_W(PL_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .selector    (selector),
    .descDpl     (descDpl),
    .descPresent (descPresent),
    .curCpl      (curCpl),
    .viaGate     (viaGate),
    .tableLimit  (tableLimit),
    .strb        (strb),
    .flags       (flags),
    .faultValid  (faultValid),
    .faultType   (faultType),
    .errCode     (errCode),
    .okPulse     (okPulse)
  );
endmodule

// File: tb/sim_segProtChk.sv
module sim_segProtChk;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] selector = '0;
  logic [1:0]  descDpl = '0;
  logic        descPresent = 1'b1;
  logic [1:0]  curCpl = '0;
  logic        viaGate = 1'b0;
  logic [15:0] tableLimit = '0;
  logic        faultValid, okPulse;
  logic [1:0]  faultType;
  logic [15:0] errCode;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  segProtChk u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .selector(selector),
    .descDpl(descDpl), .descPresent(descPresent), .curCpl(curCpl),
    .viaGate(viaGate), .tableLimit(tableLimit), .faultValid(faultValid),
    .faultType(faultType), .errCode(errCode), .okPulse(okPulse)
  );

  typedef struct packed {
    logic [15:0] sel;
    logic [1:0]  dpl;
    logic        pres;
    logic [1:0]  cpl;
    logic        gate;
    logic [15:0] lim;
    logic        expFault;
    logic [1:0]  expType;
    logic [15:0] expErr;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 15;
  localparam vecT VEC [NV] = '{
    '{16'h0010, 2'd0, 1'b1, 2'd0, 1'b0, 16'h00FF, 1'b0, 2'd0, 16'h0000, 4'd9},  // R9 clean
    '{16'h0013, 2'd0, 1'b1, 2'd0, 1'b0, 16'h00FF, 1'b1, 2'd1, 16'h0013, 4'd2},  // R2 rpl>cpl
    '{16'h0010, 2'd1, 1'b1, 2'd0, 1'b0, 16'h00FF, 1'b1, 2'd1, 16'h0010, 4'd2},  // R2 dpl!=cpl
    '{16'h0012, 2'd2, 1'b0, 2'd2, 1'b0, 16'h00FF, 1'b1, 2'd2, 16'h0012, 4'd3},  // R3 absent
    '{16'h0010, 2'd3, 1'b0, 2'd0, 1'b0, 16'h00FF, 1'b1, 2'd1, 16'h0010, 4'd4},  // R4
    '{16'h0000, 2'd1, 1'b0, 2'd0, 1'b1, 16'h0003, 1'b1, 2'd1, 16'h0000, 4'd7},  // R7 null tiny limit
    '{16'h0003, 2'd0, 1'b1, 2'd0, 1'b1, 16'h00FF, 1'b1, 2'd1, 16'h0000, 4'd5},  // R5 null rpl3
    '{16'h0100, 2'd1, 1'b0, 2'd0, 1'b1, 16'h00FF, 1'b1, 2'd1, 16'h0100, 4'd6},  // R6 over limit
    '{16'h00F8, 2'd0, 1'b1, 2'd0, 1'b1, 16'h00FF, 1'b0, 2'd0, 16'h0000, 4'd6},  // R6 ends on limit
    '{16'h0100, 2'd0, 1'b1, 2'd0, 1'b1, 16'h0107, 1'b0, 2'd0, 16'h0000, 4'd6},  // R6 exact fit
    '{16'h0100, 2'd0, 1'b1, 2'd0, 1'b1, 16'h0106, 1'b1, 2'd1, 16'h0100, 4'd6},  // R6 one byte short
    '{16'h0004, 2'd0, 1'b1, 2'd0, 1'b1, 16'h0003, 1'b1, 2'd1, 16'h0004, 4'd6},  // R6 TI set
    '{16'h0100, 2'd0, 1'b1, 2'd0, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0000, 4'd8},  // R8 limit ignored
    '{16'h0000, 2'd0, 1'b1, 2'd0, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0000, 4'd8},  // R8 null ignored
    '{16'h0019, 2'd3, 1'b1, 2'd3, 1'b0, 16'h00FF, 1'b0, 2'd0, 16'h0000, 4'd10}  // R10 ok at level 3
  };

  task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pack(input logic f, input logic o, input logic [1:0] t, input logic [15:0] e);
    return {f, o, t, e};
  endfunction

  function automatic string rname(input logic [3:0] n);
    return $sformatf("R%0d", n);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nFails++;
        nChecks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
        $finish;
      end
    end
  end

  initial begin
    logic [19:0] got, want;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pack(faultValid, okPulse, faultType, errCode) == 20'h0, "R1 reset",
        pack(faultValid, okPulse, faultType, errCode), 20'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      selector    = VEC[i].sel;
      descDpl     = VEC[i].dpl;
      descPresent = VEC[i].pres;
      curCpl      = VEC[i].cpl;
      viaGate     = VEC[i].gate;
      tableLimit  = VEC[i].lim;
      inValid     = 1'b1;
      @(negedge clk);
      got  = pack(faultValid, okPulse, faultType, errCode);
      want = pack(VEC[i].expFault, !VEC[i].expFault, VEC[i].expType, VEC[i].expErr);
      chk(got == want, rname(VEC[i].req), got, want);
    end

    // R1 idle after a strobe: outputs drop
    inValid = 1'b0;
    selector = 16'h0013;
    @(negedge clk);
    got = pack(faultValid, okPulse, faultType, errCode);
    chk(got == 20'h0, "R1 idle", got, 20'h0);

    // R1 back-to-back: fault then ok
    selector = 16'h0012; descDpl = 2'd2; curCpl = 2'd2; descPresent = 1'b0;
    viaGate = 1'b0; inValid = 1'b1;
    @(negedge clk);
    got = pack(faultValid, okPulse, faultType, errCode);
    chk(got == pack(1'b1, 1'b0, 2'd2, 16'h0012), "R1 b2b first", got, pack(1'b1, 1'b0, 2'd2, 16'h0012));
    descPresent = 1'b1;
    @(negedge clk);
    got = pack(faultValid, okPulse, faultType, errCode);
    chk(got == pack(1'b0, 1'b1, 2'd0, 16'h0), "R9 b2b second", got, pack(1'b0, 1'b1, 2'd0, 16'h0));

    // R1 reset mid-run clears a pending fault
    descPresent = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    #1;
    got = pack(faultValid, okPulse, faultType, errCode);
    chk(got == 20'h0, "R1 async reset", got, 20'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule